// File: doc/BRIEF.md
# Cascaded Vectored Interrupt Arbiter

This block merges two interrupt controllers of 32 request lines each into one arbiter over 64 sources. Controller 1 serves sources 0 to 31 and controller 2 serves sources 32 to 63. Each request is masked by a per-source enable. Each controller also has a bank of programmable vector slots. A slot holds a source index and an enable. A source named by an enabled slot is vectored, and every other eligible source is unvectored.

One arbitrated result is published as a shared, registered vector word. The word carries a tag that separates four cases: nothing pending, a vectored source together with its full 6-bit source number, an unvectored source on controller 1, and an unvectored source on controller 2. Software reads this one word and does not need to know which controller raised the interrupt. A synchronous write port programs the enable masks and the slots.

Top module: `cascade_irq_arbiter`

## Requirements
- R1: Request bit k of `req_a` is source k, and request bit k of `req_b` is source 32+k. A vectored winner reports this full source number.
- R2: A source is eligible only while both its raw request bit and its per-source enable bit are 1. All per-source enables and all slot enables clear to 0 on reset.
- R3: An eligible vectored source on either controller wins over every eligible unvectored source on either controller.
- R4: The four classes rank as follows, highest first: vectored on controller 1, vectored on controller 2, unvectored on controller 1, unvectored on controller 2.
- R5: A vectored winner gives `vec_word` = 0x100 | source number. Bit 8 is set, bits 5:0 hold the number (0 to 63), and bits 7:6, 9 and 10 are 0. Source 0 therefore reads 0x100.
- R6: An unvectored winner on controller 1 gives `vec_word` = 0x200, with the low byte 0.
- R7: An unvectored winner on controller 2 gives `vec_word` = 0x400, with the low byte 0.
- R8: With no eligible source, `vec_word` = 0x000.
- R9: Within one controller, the lowest-numbered enabled slot whose source is eligible wins. Two enabled slots that name the same source give the same result as one.
- R10: A slot is written with `wr_is_slot`=1. `wr_slot` gives the slot index, `wr_data[5]` is the slot enable and `wr_data[4:0]` is the request bit. A source is vectored only while at least one enabled slot names it; otherwise it competes as unvectored.
- R11: A write with `wr_is_slot`=0 replaces the whole enable mask of the controller picked by `wr_sel` (0 = controller 1, 1 = controller 2) with `wr_data`.
- R12: `vec_word` is a register. It shows the result of the request, enable and slot state that was present at the previous rising clock edge, and it is 0 during and right after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_a | input | 32 | Raw requests of controller 1 (sources 0 to 31) |
| req_b | input | 32 | Raw requests of controller 2 (sources 32 to 63) |
| wr_en | input | 1 | Write strobe for the configuration port |
| wr_sel | input | 1 | Controller select for the write: 0 = controller 1, 1 = controller 2 |
| wr_is_slot | input | 1 | 1 = slot write, 0 = enable mask write |
| wr_slot | input | 4 | Slot index for a slot write |
| wr_data | input | 32 | Enable mask, or {enable, source index} in bits 5:0 |
| vec_word | output | 11 | Registered shared vector word |

## Verification
The bench builds the block with its default parameters: 32 sources and 16 slots per controller. With these values the highest request bit of each controller can be driven, the 0x138 code of a controller 2 vectored source appears, and source 0 can be vectored. Using slot indices 0, 1, 2, 3 and 5 of one bank shows that slot order, not source order, decides the winner. It also shows that a duplicated or disabled slot changes the class of a source only when no other enabled slot still names it.

// File: rtl/cva_pkg.sv
package cva_pkg;
  localparam int unsigned CVA_SRC_PER_CTRL = 32;
  localparam int unsigned CVA_SLOTS        = 16;
  localparam int unsigned CVA_WORD_W       = 11;
  localparam int unsigned CVA_TAG_VEC      = 8;
  localparam int unsigned CVA_TAG_NV1      = 9;
  localparam int unsigned CVA_TAG_NV2      = 10;
endpackage

// File: rtl/cva_prio_enc.sv
module cva_prio_enc #(
  parameter int N = 16,
  parameter int W = 4
) (
  input  logic [N-1:0] vec,
  output logic         found,
  output logic [W-1:0] idx
);
  always_comb begin
    found = |vec;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = W'(i);
    end
  end
endmodule

// File: rtl/cva_slot_bank.sv
module cva_slot_bank #(
  parameter int SRC_N  = 32,
  parameter int SLOT_N = 16,
  parameter int IDX_W  = 5,
  parameter int SLOT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_is_slot,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic [SRC_N-1:0]  wr_data,
  input  logic [SRC_N-1:0]  req,
  output logic              vec_hit,
  output logic [IDX_W-1:0]  vec_src,
  output logic              nv_hit
);
  logic [SRC_N-1:0]  src_en;
  logic [SLOT_N-1:0] slot_en;
  logic [IDX_W-1:0]  slot_src [SLOT_N];

  // enable bits carry a reset; the index array does not, so it can map to plain storage
  always_ff @(posedge clk) begin
    if (rst) begin
      src_en  <= '0;
      slot_en <= '0;
    end else if (wr_en) begin
      if (!wr_is_slot) src_en <= wr_data;
      else             slot_en[wr_slot] <= wr_data[IDX_W];
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && wr_is_slot) slot_src[wr_slot] <= wr_data[IDX_W-1:0];
  end

  logic [SRC_N-1:0]  masked;
  logic [SLOT_N-1:0] slot_hit;
  logic [SRC_N-1:0]  named [SLOT_N];
  logic [SRC_N-1:0]  vect_mask;
  logic [SLOT_W-1:0] win_slot;

  assign masked = req & src_en;

  for (genvar s = 0; s < SLOT_N; s++) begin : g_slot
    assign slot_hit[s] = slot_en[s] & masked[slot_src[s]];
    assign named[s]    = slot_en[s] ? (SRC_N'(1) << slot_src[s]) : '0;
  end

  always_comb begin
    vect_mask = '0;
    for (int s = 0; s < SLOT_N; s++) vect_mask = vect_mask | named[s];
  end

  cva_prio_enc #(.N(SLOT_N), .W(SLOT_W)) u_slot_enc (
    .vec   (slot_hit),
    .found (vec_hit),
    .idx   (win_slot)
  );

  assign vec_src = slot_src[win_slot];
  assign nv_hit  = |(masked & ~vect_mask);
endmodule

// File: rtl/cva_word_build.sv
module cva_word_build
  import cva_pkg::*;
#(
  parameter int IDX_W  = 5,
  parameter int WORD_W = CVA_WORD_W
) (
  input  logic [1:0]        v_hit,
  input  logic [IDX_W-1:0]  v_src0,
  input  logic [IDX_W-1:0]  v_src1,
  input  logic [1:0]        nv_hit,
  output logic [WORD_W-1:0] word
);
  localparam int NUM_W = IDX_W + 1;

  logic [NUM_W-1:0] num;

  always_comb begin
    word = '0;
    num  = '0;
    if (v_hit[0]) begin
      num  = {1'b0, v_src0};
      word = WORD_W'(1 << CVA_TAG_VEC) | WORD_W'(num);
    end else if (v_hit[1]) begin
      num  = {1'b1, v_src1};
      word = WORD_W'(1 << CVA_TAG_VEC) | WORD_W'(num);
    end else if (nv_hit[0]) begin
      word = WORD_W'(1 << CVA_TAG_NV1);
    end else if (nv_hit[1]) begin
      word = WORD_W'(1 << CVA_TAG_NV2);
    end
  end
endmodule

// File: rtl/cascade_irq_arbiter.sv
module cascade_irq_arbiter
  import cva_pkg::*;
#(
  parameter int SRC_PER_CTRL = CVA_SRC_PER_CTRL,
  parameter int SLOT_CNT     = CVA_SLOTS,
  parameter int WORD_W       = CVA_WORD_W,
  localparam int IDX_W       = $clog2(SRC_PER_CTRL),
  localparam int SLOT_W      = $clog2(SLOT_CNT)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [SRC_PER_CTRL-1:0] req_a,
  input  logic [SRC_PER_CTRL-1:0] req_b,
  input  logic                    wr_en,
  input  logic                    wr_sel,
  input  logic                    wr_is_slot,
  input  logic [SLOT_W-1:0]       wr_slot,
  input  logic [SRC_PER_CTRL-1:0] wr_data,
  output logic [WORD_W-1:0]       vec_word
);
  localparam int CTRL_N = 2;

  logic [SRC_PER_CTRL-1:0] req_arr [CTRL_N];
  logic [IDX_W-1:0]        vsrc    [CTRL_N];
  logic [CTRL_N-1:0]       vhit;
  logic [CTRL_N-1:0]       nvhit;
  logic [WORD_W-1:0]       word_next;

  assign req_arr[0] = req_a;
  assign req_arr[1] = req_b;

  for (genvar g = 0; g < CTRL_N; g++) begin : g_ctrl
    cva_slot_bank #(
      .SRC_N  (SRC_PER_CTRL),
      .SLOT_N (SLOT_CNT),
      .IDX_W  (IDX_W),
      .SLOT_W (SLOT_W)
    ) u_bank (
      .clk        (clk),
      .rst        (rst),
      .wr_en      (wr_en && (wr_sel == 1'(g))),
      .wr_is_slot (wr_is_slot),
      .wr_slot    (wr_slot),
      .wr_data    (wr_data),
      .req        (req_arr[g]),
      .vec_hit    (vhit[g]),
      .vec_src    (vsrc[g]),
      .nv_hit     (nvhit[g])
    );
  end

  cva_word_build #(.IDX_W(IDX_W), .WORD_W(WORD_W)) u_word (
    .v_hit  (vhit),
    .v_src0 (vsrc[0]),
    .v_src1 (vsrc[1]),
    .nv_hit (nvhit),
    .word   (word_next)
  );

  always_ff @(posedge clk) begin
    if (rst) vec_word <= '0;
    else     vec_word <= word_next;
  end
endmodule

// File: rtl/cascade_irq_arbiter_chk.sv
module cascade_irq_arbiter_chk #(
  parameter int SRC_N  = 32,
  parameter int WORD_W = 11
) (
  input logic              clk,
  input logic              rst,
  input logic [SRC_N-1:0]  req_a,
  input logic [SRC_N-1:0]  req_b,
  input logic [WORD_W-1:0] vec_word
);
  logic [2*SRC_N-1:0] req_d;

  always_ff @(posedge clk) req_d <= {req_b, req_a};

  p_reset_clear_r12: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> vec_word == '0);

  p_tags_exclusive_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(vec_word[10:8]));

  p_vec_field_r5: assert property (@(posedge clk) disable iff (rst)
    vec_word[8] |-> vec_word[7:6] == 2'b00);

  p_nv_low_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (vec_word[9] || vec_word[10]) |-> vec_word[7:0] == 8'h00);  // also covers R7

  p_vec_had_req_r2: assert property (@(posedge clk) disable iff (rst)
    vec_word[8] |-> req_d[vec_word[5:0]]);

  p_nv1_had_req_r6: assert property (@(posedge clk) disable iff (rst)
    vec_word[9] |-> req_d[SRC_N-1:0] != '0);

  p_nv2_had_req_r7: assert property (@(posedge clk) disable iff (rst)
    vec_word[10] |-> req_d[2*SRC_N-1:SRC_N] != '0);

  p_idle_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (req_d == '0) |-> vec_word == '0);
endmodule

bind cascade_irq_arbiter cascade_irq_arbiter_chk #(
  .SRC_N  (SRC_PER_CTRL),
  .WORD_W (WORD_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .req_a    (req_a),
  .req_b    (req_b),
  .vec_word (vec_word)
);

// File: tb/cascade_irq_arbiter_bench.sv
`timescale 1ns/1ps
module cascade_irq_arbiter_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] req_a = '0;
  logic [31:0] req_b = '0;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic        wr_is_slot = 1'b0;
  logic [3:0]  wr_slot = '0;
  logic [31:0] wr_data = '0;
  logic [10:0] vec_word;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cascade_irq_arbiter u_cascade_irq_arbiter (
    .clk(clk), .rst(rst), .req_a(req_a), .req_b(req_b),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_is_slot(wr_is_slot),
    .wr_slot(wr_slot), .wr_data(wr_data), .vec_word(vec_word)
  );

  // {requirement number, req_a, req_b, expected word}
  localparam int NV = 14;
  localparam logic [78:0] TBL [NV] = '{
    {4'd8,  32'h0000_0000, 32'h0000_0000, 11'h000}, // R8 nothing pending
    {4'd6,  32'h0000_0001, 32'h0000_0000, 11'h200}, // R6 unvectored ctrl1
    {4'd7,  32'h0000_0000, 32'h0000_0002, 11'h400}, // R7 unvectored ctrl2
    {4'd4,  32'h0000_0001, 32'h0000_0002, 11'h200}, // R4 nv1 over nv2
    {4'd1,  32'h0000_0000, 32'h0100_0000, 11'h138}, // R1 ctrl2 bit 24 is source 56
    {4'd3,  32'h0000_0001, 32'h0100_0000, 11'h138}, // R3 vectored ctrl2 beats nv ctrl1
    {4'd4,  32'h0000_0080, 32'h0100_0000, 11'h107}, // R4 vectored ctrl1 first
    {4'd9,  32'h0000_0088, 32'h0000_0000, 11'h103}, // R9 slot 0 over slot 1
    {4'd9,  32'h0000_0000, 32'h0100_0020, 11'h138}, // R9 slot 0 over slot 2
    {4'd1,  32'h0000_0000, 32'h0000_0020, 11'h125}, // R1 ctrl2 bit 5 is source 37
    {4'd4,  32'hFFFF_FFFF, 32'hFFFF_FFFF, 11'h103}, // R4 all requests
    {4'd6,  32'h8000_0000, 32'h0000_0000, 11'h200}, // R6 top bit ctrl1
    {4'd7,  32'h0000_0000, 32'h8000_0000, 11'h400}, // R7 top bit ctrl2
    {4'd5,  32'h0000_0008, 32'h0000_0000, 11'h103}  // R5 code layout
  };

  task automatic check(input string tag, input logic [10:0] exp);
    checks++;
    if (vec_word !== exp) begin
      errors++;
      $display("FAIL %s: vec_word actual 0x%03h expected 0x%03h", tag, vec_word, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic is_slot, input logic [3:0] slot,
                    input logic [31:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_is_slot = is_slot; wr_slot = slot; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic apply(input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    req_a = a; req_b = b;
    @(negedge clk);
  endtask

  initial begin
    // R12 reset state
    repeat (3) @(negedge clk);
    check("R12 during reset", 11'h000);
    rst = 1'b0;
    // R2 enables clear after reset
    apply(32'hFFFF_FFFF, 32'hFFFF_FFFF);
    check("R2 no enables after reset", 11'h000);
    // R11 enable mask writes
    wr(1'b0, 1'b0, 4'd0, 32'hFFFF_FFFF);
    apply(32'hFFFF_FFFF, 32'hFFFF_FFFF);
    check("R11 ctrl1 mask", 11'h200);
    apply(32'h0, 32'hFFFF_FFFF);
    check("R2 ctrl2 still masked", 11'h000);
    wr(1'b1, 1'b0, 4'd0, 32'hFFFF_FFFF);
    apply(32'h0, 32'hFFFF_FFFF);
    check("R11 ctrl2 mask", 11'h400);
    // R10 slot programming
    wr(1'b0, 1'b1, 4'd0, 32'h23);  // ctrl1 slot0 -> bit 3
    wr(1'b0, 1'b1, 4'd1, 32'h27);  // ctrl1 slot1 -> bit 7
    wr(1'b1, 1'b1, 4'd0, 32'h38);  // ctrl2 slot0 -> bit 24
    wr(1'b1, 1'b1, 4'd2, 32'h25);  // ctrl2 slot2 -> bit 5

    for (int i = 0; i < NV; i++) begin
      apply(TBL[i][74:43], TBL[i][42:11]);
      check($sformatf("R%0d vector %0d", TBL[i][78:75], i), TBL[i][10:0]);
    end

    // R2 a masked source is ignored even though a slot names it
    wr(1'b0, 1'b0, 4'd0, 32'hFFFF_FFF7);
    apply(32'h0000_0008, 32'h0);
    check("R2 masked vectored source", 11'h000);
    wr(1'b0, 1'b0, 4'd0, 32'hFFFF_FFFF);
    // R9 duplicate slot naming bit 3
    wr(1'b0, 1'b1, 4'd5, 32'h23);
    apply(32'h0000_0088, 32'h0);
    check("R9 duplicate slot", 11'h103);
    // R10 disable slot0: slot1 (bit 7) now ranks above slot5 (bit 3)
    wr(1'b0, 1'b1, 4'd0, 32'h03);
    apply(32'h0000_0088, 32'h0);
    check("R10 slot order after disable", 11'h107);
    wr(1'b0, 1'b1, 4'd5, 32'h03);
    apply(32'h0000_0008, 32'h0);
    check("R10 source falls back to unvectored", 11'h200);
    // R5 vectored source 0
    wr(1'b0, 1'b1, 4'd3, 32'h20);
    apply(32'h0000_0001, 32'h0);
    check("R5 source zero", 11'h100);
    // R12 one clock of latency
    @(negedge clk);
    req_a = 32'h0;
    #1;
    check("R12 old value before edge", 11'h100);
    @(negedge clk);
    check("R12 new value after edge", 11'h000);
    // R12 reset mid-run, R2 enables cleared again
    req_a = 32'h0000_0001;
    rst = 1'b1;
    @(negedge clk);
    check("R12 reset mid-run", 11'h000);
    rst = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R2 enables cleared by reset", 11'h000);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule